// File: doc/BRIEF.md
# DRAM Distributed Refresh Scheduler

This block keeps an asynchronous DRAM alive by spreading CAS-before-RAS refresh cycles evenly over the retention period. A free-running interval counter marks each moment a row refresh becomes owed. Owed refreshes collect in a small backlog. The block asks an external access arbiter for the memory bus and, once the arbiter grants it, drives the row and column strobes through the refresh sequence. The device's internal row counter picks the row, so no address is ever driven. The write-enable strobe stays high throughout.

The interval follows from two parameters: the retention period in controller clock cycles and the number of rows (2048 or 4096). The arbiter may postpone refreshes. When the backlog reaches its limit, an urgency flag tells the arbiter to give priority. A self-refresh path is also provided. It starts a CAS-before-RAS cycle and keeps the row strobe low until an exit request arrives and a minimum hold time has passed. It then enforces a longer recovery precharge. Because refresh has been distributed, the backlog is dropped on exit, so no burst of catch-up cycles follows.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset, ras_n, cas_n and we_n are high, and refresh_req, refresh_urgent, refresh_done and sr_active are low.
- R2: One refresh becomes owed every ROW_INTERVAL = PERIOD_CYCLES / ROW_COUNT cycles. After reset release with no grant, refresh_req rises ROW_INTERVAL clock edges later.
- R3: Without refresh_gnt, a request is held and ras_n and cas_n stay high.
- R4: Once granted, cas_n is low with ras_n high for T_CSR cycles, and then both are low for T_RAS cycles.
- R5: we_n is high in every cycle.
- R6: After the strobes release, both stay high for T_RP cycles. refresh_done is then high for exactly one cycle, during which refresh_req is low.
- R7: The backlog saturates at MAX_PEND owed refreshes. refresh_urgent is high exactly when the backlog is full. A held grant services every owed refresh back to back, one cycle each.
- R8: A sr_enter pulse leads, once granted, to a CAS-before-RAS entry in which ras_n stays low, with sr_active high, for at least T_RASS cycles, even if exit is asked early.
- R9: After the minimum hold, ras_n rises in response to sr_exit. Both strobes then stay high for T_RPS cycles before refresh_done.
- R10: Leaving self refresh discards the owed backlog and restarts the interval, so no refresh request follows right after exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| refresh_gnt | input | 1 | Arbiter grants the DRAM bus to the scheduler |
| sr_enter | input | 1 | Pulse requesting entry into self refresh |
| sr_exit | input | 1 | Pulse requesting exit from self refresh |
| refresh_req | output | 1 | Scheduler needs the bus |
| refresh_urgent | output | 1 | Backlog full, request needs priority |
| refresh_done | output | 1 | One-cycle pulse at end of a refresh or self-refresh exit |
| sr_active | output | 1 | Device is held in self refresh |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low, held high |

## Verification
The hardest states to reach are a full backlog that then gets one more tick, and a self-refresh exit that arrives before or after the minimum hold. The bench withholds the grant for nine intervals, so the backlog is provably saturated. It then grants and counts the done pulses inside one interval window. For self refresh it first lets three refreshes fall due, then enters. It pulses the exit request either after three low cycles or after fifteen. From the strobe lengths it sees, the bench tells whether the hold was stretched or the exit taken at once. It then watches the request line to confirm the backlog was dropped.

// File: rtl/rfsh_pkg.sv
// Package: shared types and helpers for the refresh scheduler.
// Assumes: nothing beyond IEEE 1800-2017.
package rfsh_pkg;

    // Sequencer states for one refresh or self-refresh excursion.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CSET   = 3'd1,
        ST_RLOW   = 3'd2,
        ST_SRHOLD = 3'd3,
        ST_PRE    = 3'd4,
        ST_DONE   = 3'd5
    } rfsh_state_e;

    // Larger of two integers, used to size shared timers.
    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rfsh_interval.sv
// Module: rfsh_interval
// Counts controller cycles and emits a one-cycle tick every ROW_INTERVAL
// cycles. The count is frozen while 'hold' is high and restarts from zero
// on 'restart'.
// Assumes: ROW_INTERVAL >= 2.
module rfsh_interval #(
    parameter int ROW_INTERVAL = 7812
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic restart,
    output logic tick
);
    localparam int CW = $clog2(ROW_INTERVAL);

    logic [CW-1:0] cnt;

    // A tick is due when the last cycle of the interval is reached.
    assign tick = !hold && (cnt == CW'(ROW_INTERVAL - 1));

    // Interval counter: wraps on tick, freezes on hold, clears on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt <= '0;
        end else if (!hold) begin
            cnt <= tick ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/rfsh_backlog.sv
// Module: rfsh_backlog
// Tracks the number of refreshes owed. A tick adds one (saturating at
// MAX_PEND), a serviced refresh removes one, and clear empties it.
// Assumes: served is never pulsed while the count is zero.
module rfsh_backlog #(
    parameter int MAX_PEND = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic served,
    input  logic clear,
    output logic owed,
    output logic urgent
);
    localparam int PW = $clog2(MAX_PEND + 1);
    localparam logic [PW-1:0] FULL = PW'(MAX_PEND);

    logic [PW-1:0] pend;

    assign owed   = (pend != '0);
    assign urgent = (pend == FULL);

    // Backlog counter update.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pend <= '0;
        end else begin
            unique case ({tick, served})
                2'b10:   pend <= (pend == FULL) ? pend : pend + 1'b1;
                2'b01:   pend <= (pend == '0) ? pend : pend - 1'b1;
                default: pend <= pend;
            endcase
        end
    end

    // R7: a full backlog never exceeds its limit on another tick.
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (urgent && tick && !served && !clear) |=> urgent);

    // R7: the count stays within its limit.
    a_r7_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pend <= FULL);

    // R10: a clear leaves nothing owed.
    a_r10_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !owed);

endmodule

// File: rtl/rfsh_seq.sv
// Module: rfsh_seq
// Strobe sequencer. It requests the bus when a refresh is owed or self
// refresh is wanted. Once granted, it drives CAS low ahead of RAS, holds
// both, and releases them through a precharge, then pulses done. In self
// refresh, RAS is held until exit is asked and T_RASS has passed, and the
// precharge is then T_RPS long. The strobes are registered.
// Assumes: the arbiter keeps refresh_gnt high until done; all times >= 1.
module rfsh_seq
    import rfsh_pkg::*;
#(
    parameter int T_CSR  = 3,
    parameter int T_RAS  = 13,
    parameter int T_RP   = 8,
    parameter int T_RASS = 25000,
    parameter int T_RPS  = 28
) (
    input  logic clk,
    input  logic rst_n,
    input  logic owed,
    input  logic gnt,
    input  logic sr_enter,
    input  logic sr_exit,
    output logic req,
    output logic done,
    output logic served,
    output logic sr_done,
    output logic sr_busy,
    output logic sr_active,
    output logic ras_n,
    output logic cas_n
);
    localparam int TMAX = max_int(max_int(max_int(T_CSR, T_RAS), max_int(T_RP, T_RPS)), T_RASS);
    localparam int TW   = $clog2(TMAX + 1);
    localparam int LW   = $clog2(T_RASS + 2);

    rfsh_state_e   state, state_d;
    logic [TW-1:0] cnt, cnt_d;
    logic          sr_pend, sr_mode, exit_flag, start;

    // Next-state and timer logic for one excursion.
    always_comb begin
        state_d = state;
        cnt_d   = cnt;
        start   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if ((owed || sr_pend) && gnt) begin
                    state_d = ST_CSET;
                    cnt_d   = TW'(T_CSR - 1);
                    start   = 1'b1;
                end
            end
            ST_CSET: begin
                if (cnt != '0) begin
                    cnt_d = cnt - 1'b1;
                end else if (sr_mode) begin
                    state_d = ST_SRHOLD;
                    cnt_d   = TW'(T_RASS - 1);
                end else begin
                    state_d = ST_RLOW;
                    cnt_d   = TW'(T_RAS - 1);
                end
            end
            ST_RLOW: begin
                if (cnt != '0) begin
                    cnt_d = cnt - 1'b1;
                end else begin
                    state_d = ST_PRE;
                    cnt_d   = TW'(T_RP - 1);
                end
            end
            ST_SRHOLD: begin
                if (cnt != '0) begin
                    cnt_d = cnt - 1'b1;
                end else if (exit_flag || sr_exit) begin
                    state_d = ST_PRE;
                    cnt_d   = TW'(T_RPS - 1);
                end
            end
            ST_PRE: begin
                if (cnt != '0) begin
                    cnt_d = cnt - 1'b1;
                end else begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State, timer and registered strobe decode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            ras_n <= 1'b1;
            cas_n <= 1'b1;
        end else begin
            state <= state_d;
            cnt   <= cnt_d;
            ras_n <= !(state_d inside {ST_RLOW, ST_SRHOLD});
            cas_n <= !(state_d inside {ST_CSET, ST_RLOW, ST_SRHOLD});
        end
    end

    // Self-refresh entry request: latched until an excursion takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_pend <= 1'b0;
        end else if (start && sr_pend) begin
            sr_pend <= 1'b0;
        end else if (sr_enter && !sr_busy) begin
            sr_pend <= 1'b1;
        end
    end

    // Kind of the current excursion, fixed at its start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_mode <= 1'b0;
        end else if (start) begin
            sr_mode <= sr_pend;
        end
    end

    // Exit request seen during the minimum hold, kept until it is honoured.
    always_ff @(posedge clk) begin
        if (!rst_n || state != ST_SRHOLD) begin
            exit_flag <= 1'b0;
        end else if (sr_exit) begin
            exit_flag <= 1'b1;
        end
    end

    assign req       = (state == ST_IDLE) ? (owed || sr_pend) : (state != ST_DONE);
    assign done      = (state == ST_DONE);
    assign served    = done && !sr_mode;
    assign sr_done   = done && sr_mode;
    assign sr_busy   = sr_mode && (state != ST_IDLE);
    assign sr_active = (state == ST_SRHOLD);

    // Checker counter: length of the current RAS low time.
    logic [LW-1:0] ras_low_len;
    always_ff @(posedge clk) begin
        if (!rst_n || ras_n) begin
            ras_low_len <= '0;
        end else if (ras_low_len != LW'(T_RASS + 1)) begin
            ras_low_len <= ras_low_len + 1'b1;
        end
    end

    // R4: CAS was already low in the cycle before RAS falls.
    a_r4_cas_before_ras: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

    // R3: CAS only falls while the bus is granted.
    a_r3_grant_first: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> $past(gnt));

    // R6: both strobes release together.
    a_r6_release_together: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> $rose(cas_n));

    // R6: done is a single-cycle pulse.
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: a self-refresh RAS low time is never shorter than T_RASS.
    a_r8_min_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ras_n) && $past(sr_active)) |-> (ras_low_len >= LW'(T_RASS)));

endmodule

// File: rtl/dram_refresh_sched.sv
// Module: dram_refresh_sched (top)
// Distributed CAS-before-RAS refresh scheduler with a self-refresh path.
// ROW_INTERVAL is derived from the retention period and the row count
// (2048 or 4096). It joins the interval timer, the owed-refresh backlog
// and the strobe sequencer.
// Assumes: the arbiter holds refresh_gnt from grant until refresh_done.
module dram_refresh_sched #(
    parameter int PERIOD_CYCLES = 32_000_000,
    parameter int ROW_COUNT     = 4096,
    parameter int MAX_PEND      = 8,
    parameter int T_CSR         = 3,
    parameter int T_RAS         = 13,
    parameter int T_RP          = 8,
    parameter int T_RASS        = 25000,
    parameter int T_RPS         = 28
) (
    input  logic clk,
    input  logic rst_n,
    input  logic refresh_gnt,
    input  logic sr_enter,
    input  logic sr_exit,
    output logic refresh_req,
    output logic refresh_urgent,
    output logic refresh_done,
    output logic sr_active,
    output logic ras_n,
    output logic cas_n,
    output logic we_n
);
    localparam int ROW_INTERVAL = PERIOD_CYCLES / ROW_COUNT;

    logic tick, owed, served, sr_done, sr_busy;

    // CBR ordering needs write enable high throughout.
    assign we_n = 1'b1;

    rfsh_interval #(
        .ROW_INTERVAL(ROW_INTERVAL)
    ) u_interval (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (sr_busy),
        .restart (sr_done),
        .tick    (tick)
    );

    rfsh_backlog #(
        .MAX_PEND(MAX_PEND)
    ) u_backlog (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .served (served),
        .clear  (sr_done),
        .owed   (owed),
        .urgent (refresh_urgent)
    );

    rfsh_seq #(
        .T_CSR  (T_CSR),
        .T_RAS  (T_RAS),
        .T_RP   (T_RP),
        .T_RASS (T_RASS),
        .T_RPS  (T_RPS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .owed      (owed),
        .gnt       (refresh_gnt),
        .sr_enter  (sr_enter),
        .sr_exit   (sr_exit),
        .req       (refresh_req),
        .done      (refresh_done),
        .served    (served),
        .sr_done   (sr_done),
        .sr_busy   (sr_busy),
        .sr_active (sr_active),
        .ras_n     (ras_n),
        .cas_n     (cas_n)
    );

    // R5: write enable never drops.
    a_r5_we_high: assert property (@(posedge clk) disable iff (!rst_n)
        we_n && $stable(we_n));

endmodule

// File: tb/tb_dram_refresh_sched.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_dram_refresh_sched;
    localparam int ROWS = 2048;
    localparam int IVL  = 200;
    localparam int CSR  = 2;
    localparam int RAS  = 4;
    localparam int RP   = 3;
    localparam int RASS = 10;
    localparam int RPS  = 6;
    localparam int MAXP = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic refresh_gnt = 1'b0;
    logic sr_enter = 1'b0;
    logic sr_exit = 1'b0;
    logic refresh_req, refresh_urgent, refresh_done, sr_active, ras_n, cas_n, we_n;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    dram_refresh_sched #(
        .PERIOD_CYCLES (IVL * ROWS),
        .ROW_COUNT     (ROWS),
        .MAX_PEND      (MAXP),
        .T_CSR         (CSR),
        .T_RAS         (RAS),
        .T_RP          (RP),
        .T_RASS        (RASS),
        .T_RPS         (RPS)
    ) dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .refresh_gnt    (refresh_gnt),
        .sr_enter       (sr_enter),
        .sr_exit        (sr_exit),
        .refresh_req    (refresh_req),
        .refresh_urgent (refresh_urgent),
        .refresh_done   (refresh_done),
        .sr_active      (sr_active),
        .ras_n          (ras_n),
        .cas_n          (cas_n),
        .we_n           (we_n)
    );

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; refresh_gnt = 1'b0; sr_enter = 1'b0; sr_exit = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Follows one granted excursion from CAS fall to the done pulse.
    task automatic measure(input int exit_after, output int csr, output int rl,
                           output int pre, output bit sr_seen, output bit we_ok);
        int guard = 0;
        csr = 0; rl = 0; pre = 0; sr_seen = 0; we_ok = 1;
        while (cas_n && guard < 20) begin @(negedge clk); guard++; end
        while (!cas_n && ras_n) begin
            csr++; we_ok &= we_n; @(negedge clk);
        end
        while (!ras_n && rl < 1000) begin
            rl++; we_ok &= we_n;
            if (sr_active) sr_seen = 1;
            sr_exit = (rl == exit_after);
            @(negedge clk);
        end
        sr_exit = 1'b0;
        while (ras_n && cas_n && !refresh_done && pre < 100) begin
            pre++; we_ok &= we_n; @(negedge clk);
        end
    endtask

    task automatic t_reset();
        do_reset();
        check(ras_n && cas_n, "R1 strobes high", {ras_n, cas_n}, 3);
        check(!refresh_req && !refresh_done, "R1 req/done low", {refresh_req, refresh_done}, 0);
        check(!refresh_urgent && !sr_active, "R1 urgent/sr low", {refresh_urgent, sr_active}, 0);
        check(we_n, "R5 we_n after reset", we_n, 1);
    endtask

    task automatic t_interval_and_single();
        int n = 0;
        int csr, rl, pre;
        bit srs, weok, strobes_ok;
        do_reset();
        while (!refresh_req && n < 1000) begin @(posedge clk); n++; @(negedge clk); end
        check(n == IVL, "R2 interval edges", n, IVL);
        strobes_ok = 1;
        for (int i = 0; i < 30; i++) begin
            strobes_ok &= ras_n & cas_n & refresh_req;
            @(negedge clk);
        end
        check(strobes_ok, "R3 no strobes without grant", strobes_ok, 1);
        refresh_gnt = 1'b1;
        measure(-1, csr, rl, pre, srs, weok);
        check(csr == CSR, "R4 CAS-only setup", csr, CSR);
        check(rl == RAS, "R4 RAS low time", rl, RAS);
        check(pre == RP, "R6 precharge", pre, RP);
        check(refresh_done && !refresh_req, "R6 done with req low", {refresh_done, refresh_req}, 2);
        check(!srs, "R8 no self refresh on plain cycle", srs, 0);
        check(weok, "R5 we_n during cycle", weok, 1);
        refresh_gnt = 1'b0;
        @(negedge clk);
        check(!refresh_done && !refresh_req, "R6 single pulse, nothing owed", {refresh_done, refresh_req}, 0);
    endtask

    task automatic t_backlog();
        int dones = 0;
        do_reset();
        repeat (MAXP * IVL - 1) @(posedge clk);
        @(negedge clk);
        check(!refresh_urgent, "R7 not urgent one short", refresh_urgent, 0);
        @(posedge clk);
        @(negedge clk);
        check(refresh_urgent, "R7 urgent when full", refresh_urgent, 1);
        repeat (IVL) @(posedge clk);
        @(negedge clk);
        refresh_gnt = 1'b1;
        for (int i = 0; i < 150; i++) begin
            if (refresh_done) dones++;
            @(negedge clk);
        end
        refresh_gnt = 1'b0;
        check(dones == MAXP, "R7 saturated backlog serviced", dones, MAXP);
        check(!refresh_req && !refresh_urgent, "R7 backlog empty", {refresh_req, refresh_urgent}, 0);
    endtask

    task automatic t_selfref(input int exit_after, input int exp_rl);
        int csr, rl, pre;
        bit srs, weok, quiet;
        do_reset();
        repeat (3 * IVL + 10) @(posedge clk);
        @(negedge clk);
        sr_enter = 1'b1;
        @(negedge clk);
        sr_enter = 1'b0;
        refresh_gnt = 1'b1;
        measure(exit_after, csr, rl, pre, srs, weok);
        check(csr == CSR, "R8 CAS before RAS on entry", csr, CSR);
        check(srs, "R8 sr_active during hold", srs, 1);
        check(rl == exp_rl, "R9 RAS low length in self refresh", rl, exp_rl);
        check(pre == RPS, "R9 recovery precharge", pre, RPS);
        check(refresh_done, "R9 done after exit", refresh_done, 1);
        check(weok, "R5 we_n in self refresh", weok, 1);
        refresh_gnt = 1'b0;
        quiet = 1;
        for (int i = 0; i < 150; i++) begin
            @(negedge clk);
            quiet &= !refresh_req;
        end
        check(quiet, "R10 no burst after exit", quiet, 1);
    endtask

    initial begin
        t_reset();
        t_interval_and_single();
        t_backlog();
        t_selfref(3, RASS);
        t_selfref(15, 15);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule